// File: doc/BRIEF.md
# Interrupt Service Record Controller

This block gathers interrupt events from a set of logic sources into a sticky flag register and drives a single interrupt request line toward a processor. Software services interrupts in rounds. When the request is raised, software acknowledges it. The acknowledge copies every pending flag into a snapshot register, empties the flag register and sends one clear pulse back to all sources. Software then retires the snapshot bits one at a time. Events that arrive during a round collect in the flag register and start the next round once the snapshot has been emptied.

A small register port has three locations. The control location holds the new-interrupt bit. The snapshot location is write-one-to-clear. The flag location is read-to-clear: reading it returns all pending flags and clears them, which gives software a single-read fallback. Read data comes out on the clock after the read strobe. All registers use a synchronous active-high reset.

Top module: `isr_ctrl`

## Requirements
- R1: Each bit of `evt_i` that is high at a clock edge sets the matching bit of the flag register. The bit stays set until an acknowledge or a flag read clears the register.
- R2: The new-interrupt bit (bit 0 of address 0) is set on the clock edge after the snapshot is all zero while the flag register is non-zero. It stays set until an acknowledge.
- R3: `irq_o` is a register equal to (new-interrupt bit OR snapshot non-zero). It rises on the same edge as the new-interrupt bit and falls on the edge that empties the snapshot while the new-interrupt bit is clear.
- R4: A write to address 0 with bit 0 high while the new-interrupt bit is set is an acknowledge. It copies the flag register into the snapshot, clears the flag register and the new-interrupt bit, and drives `src_clr_o` high for the next cycle. A write to address 0 while the new-interrupt bit is clear, or with bit 0 low, changes nothing.
- R5: A write to address 1 clears each snapshot bit whose `wdata_i` bit is 1 and leaves the bits where it is 0. `irq_o` stays high while any snapshot bit is set.
- R6: Events after an acknowledge go only to the flag register, never to the snapshot. Once the snapshot is emptied, a non-empty flag register sets the new-interrupt bit again one clock later.
- R7: A read of address 2 returns the flag register in bits [N_SRC-1:0] on `rdata_o` after that edge. It clears the flag register and drives `src_clr_o` high for the next cycle. The new-interrupt bit is unchanged.
- R8: An event on the same edge as an acknowledge or a flag read is kept in the flag register. It is not copied into the snapshot and is not returned by that read.
- R9: After reset the flag, snapshot, new-interrupt bit, `irq_o`, `src_clr_o` and `rdata_o` are all zero.
- R10: Address 3 reads as zero. Writes to addresses 2 and 3 change no state. Address 1 reads back the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_SRC | Interrupt events, one bit per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address (0 control, 1 snapshot, 2 flags, 3 unused) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| src_clr_o | output | 1 | One-cycle clear pulse to all sources |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume a read and a write are never presented in the same cycle and that `addr_i` is always 0 to 3. The snapshot write-one-to-clear check and the acknowledge check decode the strobes on their own and assume this. The bench drives one register operation per task call and never raises both strobes together. It drives events only through explicit pulse cycles or together with a single register operation, so every collision case is deliberate.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_SNAP = 2'd1,
        ADDR_FLAG = 2'd2,
        ADDR_RSVD = 2'd3
    } isr_addr_e;

    // decoded register-port operation for one cycle
    typedef struct packed {
        logic ack_req;   // acknowledge request (still gated by new bit)
        logic snap_w1c;  // write-one-to-clear on snapshot
        logic flag_rtc;  // read-to-clear of flag register
    } isr_op_t;

    function automatic isr_op_t isr_decode(
        input logic              wr,
        input logic              rd,
        input logic [ADDR_W-1:0] addr,
        input logic              wbit0
    );
        isr_op_t op;
        op.ack_req  = wr && (isr_addr_e'(addr) == ADDR_CTRL) && wbit0;
        op.snap_w1c = wr && (isr_addr_e'(addr) == ADDR_SNAP);
        op.flag_rtc = rd && (isr_addr_e'(addr) == ADDR_FLAG);
        return op;
    endfunction

endpackage

// File: rtl/isr_flag_store.sv
module isr_flag_store #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_i,
    output logic [N_SRC-1:0] flag_o
);
    logic [N_SRC-1:0] flag_q;

    // an event on the clearing edge survives into the new contents
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= '0;
        else if (clr_i)
            flag_q <= evt_i;
        else
            flag_q <= flag_q | evt_i;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/isr_snapshot.sv
module isr_snapshot #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [N_SRC-1:0] load_val_i,
    input  logic             w1c_i,
    input  logic [N_SRC-1:0] w1c_mask_i,
    output logic [N_SRC-1:0] snap_o,
    output logic [N_SRC-1:0] snap_nxt_o,
    output logic             snap_zero_o
);
    logic [N_SRC-1:0] snap_q;
    logic [N_SRC-1:0] snap_d;

    always_comb begin
        snap_d = snap_q;
        if (load_i)
            snap_d = load_val_i;
        else if (w1c_i)
            snap_d = snap_q & ~w1c_mask_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else
            snap_q <= snap_d;
    end

    assign snap_o      = snap_q;
    assign snap_nxt_o  = snap_d;
    assign snap_zero_o = (snap_q == '0);
endmodule

// File: rtl/isr_reg_port.sv
module isr_reg_port
    import isr_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              new_i,
    input  logic [N_SRC-1:0]  snap_i,
    input  logic [N_SRC-1:0]  flag_i,
    output isr_op_t           op_o,
    output logic [N_SRC-1:0]  wmask_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] snap_ext;
    logic [DATA_W-1:0] flag_ext;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_wdata;

    assign op_o         = isr_decode(wr_en_i, rd_en_i, addr_i, wdata_i[0]);
    assign wmask_o      = wdata_i[N_SRC-1:0];
    assign unused_wdata = ^wdata_i;

    always_comb begin
        snap_ext             = '0;
        snap_ext[N_SRC-1:0]  = snap_i;
        flag_ext             = '0;
        flag_ext[N_SRC-1:0]  = flag_i;
    end

    always_comb begin
        unique case (isr_addr_e'(addr_i))
            ADDR_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, new_i};
            ADDR_SNAP: rd_mux = snap_ext;
            ADDR_FLAG: rd_mux = flag_ext;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_en_i)
            rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl
    import isr_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              src_clr_o,
    output logic              irq_o
);
    isr_op_t          op;
    logic [N_SRC-1:0] wmask;
    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] snap_q;
    logic [N_SRC-1:0] snap_nxt;
    logic             snap_zero;
    logic             new_q;
    logic             new_d;
    logic             ack;
    logic             flag_clr;
    logic             irq_q;
    logic             clr_q;

    assign ack      = op.ack_req && new_q;
    assign flag_clr = ack || op.flag_rtc;

    isr_reg_port #(.N_SRC(N_SRC)) u_port (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .new_i   (new_q),
        .snap_i  (snap_q),
        .flag_i  (flag_q),
        .op_o    (op),
        .wmask_o (wmask),
        .rdata_o (rdata_o)
    );

    isr_flag_store #(.N_SRC(N_SRC)) u_flag (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_i),
        .clr_i  (flag_clr),
        .flag_o (flag_q)
    );

    isr_snapshot #(.N_SRC(N_SRC)) u_snap (
        .clk         (clk),
        .rst         (rst),
        .load_i      (ack),
        .load_val_i  (flag_q),
        .w1c_i       (op.snap_w1c),
        .w1c_mask_i  (wmask),
        .snap_o      (snap_q),
        .snap_nxt_o  (snap_nxt),
        .snap_zero_o (snap_zero)
    );

    always_comb begin
        if (ack)
            new_d = 1'b0;
        else
            new_d = new_q || (snap_zero && (flag_q != '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            new_q <= 1'b0;
            irq_q <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            new_q <= new_d;
            irq_q <= new_d || (snap_nxt != '0);
            clr_q <= flag_clr;
        end
    end

    assign irq_o     = irq_q;
    assign src_clr_o = clr_q;
endmodule

// File: rtl/isr_ctrl_chk.sv
module isr_ctrl_chk
    import isr_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [N_SRC-1:0]  evt_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [N_SRC-1:0]  flag_q,
    input logic [N_SRC-1:0]  snap_q,
    input logic              new_q,
    input logic              ack,
    input logic              flag_clr,
    input logic              src_clr_o,
    input logic              irq_o
);
    logic snap_wr;
    assign snap_wr = wr_en_i && (addr_i == 2'd1);

    // R1
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

    // R1
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_clr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R2
    new_raise_chk: assert property (@(posedge clk) disable iff (rst)
        ((snap_q == '0) && (flag_q != '0) && !ack) |=> new_q);

    // R3
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == (new_q || (snap_q != '0)));

    // R4
    ack_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> ((snap_q == $past(flag_q)) && src_clr_o && !new_q));

    // R5
    snap_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (snap_wr && !ack) |=> (snap_q == ($past(snap_q) & ~$past(wdata_i[N_SRC-1:0]))));

    // R6
    snap_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
        !ack |=> ((snap_q & ~$past(snap_q)) == '0));

    // R8
    clr_keeps_evt_chk: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> (flag_q == $past(evt_i)));
endmodule

bind isr_ctrl isr_ctrl_chk #(.N_SRC(N_SRC)) u_isr_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .flag_q    (flag_q),
    .snap_q    (snap_q),
    .new_q     (new_q),
    .ack       (ack),
    .flag_clr  (flag_clr),
    .src_clr_o (src_clr_o),
    .irq_o     (irq_o)
);

// File: tb/test_isr_ctrl.sv
module test_isr_ctrl;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  evt = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [1:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          src_clr;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    isr_ctrl #(.N_SRC(N)) i_isr_ctrl (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .src_clr_o (src_clr),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        evt = m;
        step();
        evt = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [N-1:0] e = '0);
        wr_en = 1'b1; addr = a; wdata = d; evt = e;
        step();
        wr_en = 1'b0; wdata = '0; evt = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d, input logic [N-1:0] e = '0);
        rd_en = 1'b1; addr = a; evt = e;
        step();
        rd_en = 1'b0; evt = '0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        chk("R9 irq", {31'b0, irq}, 32'h0);
        chk("R9 src_clr", {31'b0, src_clr}, 32'h0);
        chk("R9 rdata", rdata, 32'h0);
        rd(2'd0, d); chk("R9 new bit", d, 32'h0);
        rd(2'd1, d); chk("R9 snapshot", d, 32'h0);
        rd(2'd2, d); chk("R9 flags", d, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        pulse(8'h05);
        chk("R2 irq waits one clock", {31'b0, irq}, 32'h0);
        step();
        chk("R3 irq raised with new bit", {31'b0, irq}, 32'h1);
        rd(2'd0, d); chk("R2 new bit set", d, 32'h1);
        wr(2'd0, 32'h1);
        chk("R4 clear pulse", {31'b0, src_clr}, 32'h1);
        step();
        chk("R4 clear pulse one cycle", {31'b0, src_clr}, 32'h0);
        rd(2'd1, d); chk("R4 snapshot loaded", d, 32'h05);
        rd(2'd2, d); chk("R4 flags emptied", d, 32'h0);
        rd(2'd0, d); chk("R4 new bit cleared", d, 32'h0);
        wr(2'd1, 32'h0);
        rd(2'd1, d); chk("R5 zero write keeps bits", d, 32'h05);
        wr(2'd1, 32'h1);
        rd(2'd1, d); chk("R5 one bit cleared", d, 32'h04);
        chk("R5 irq held", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'h4);
        chk("R3 irq drops on empty snapshot", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_next_round();
        logic [31:0] d;
        pulse(8'h02);
        step();
        wr(2'd0, 32'h1);
        pulse(8'h80);
        rd(2'd1, d); chk("R6 late event not in snapshot", d, 32'h02);
        rd(2'd0, d); chk("R6 no new bit while snapshot busy", d, 32'h0);
        wr(2'd1, 32'h2);
        chk("R6 irq low as snapshot empties", {31'b0, irq}, 32'h0);
        step();
        chk("R6 irq back next clock", {31'b0, irq}, 32'h1);
        rd(2'd0, d); chk("R6 new bit again", d, 32'h1);
        wr(2'd0, 32'h1);
        rd(2'd1, d); chk("R6 second round snapshot", d, 32'h80);
        wr(2'd1, 32'h80);
        chk("R5 irq cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        pulse(8'h01);
        step();
        wr(2'd0, 32'h1, 8'h10);
        rd(2'd1, d); chk("R8 colliding event not in snapshot", d, 32'h01);
        wr(2'd1, 32'h1);
        chk("R8 irq low between rounds", {31'b0, irq}, 32'h0);
        step();
        chk("R8 colliding event raises irq", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h1);
        rd(2'd1, d); chk("R8 colliding event kept", d, 32'h10);
        wr(2'd1, 32'h10);
        // read-to-clear collision
        pulse(8'h20);
        step();
        rd(2'd2, d, 8'h40);
        chk("R7 flag read value", d, 32'h20);
        chk("R7 clear pulse", {31'b0, src_clr}, 32'h1);
        rd(2'd2, d); chk("R8 event during flag read kept", d, 32'h40);
        rd(2'd2, d); chk("R7 flags cleared by read", d, 32'h0);
        rd(2'd0, d); chk("R7 new bit unchanged", d, 32'h1);
        wr(2'd0, 32'h1);
        chk("R4 ack of empty flags leaves irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(2'd0, 32'h1);
        chk("R4 ack without new bit: no pulse", {31'b0, src_clr}, 32'h0);
        rd(2'd1, d); chk("R4 ack without new bit: snapshot", d, 32'h0);
        pulse(8'h03);
        step();
        wr(2'd0, 32'h0);
        chk("R4 bit0 low: no pulse", {31'b0, src_clr}, 32'h0);
        rd(2'd0, d); chk("R4 bit0 low: new bit kept", d, 32'h1);
        wr(2'd2, 32'hFF);
        wr(2'd3, 32'hFF);
        rd(2'd3, d); chk("R10 address 3 reads zero", d, 32'h0);
        rd(2'd1, d); chk("R10 snapshot untouched", d, 32'h0);
        rd(2'd2, d); chk("R10 flags untouched by writes", d, 32'h03);
        wr(2'd0, 32'h1);
        chk("R3 idle irq", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_next_round();
        t_collide();
        t_ignored();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule